// File: doc/BRIEF.md
# RMII Frame Receiver

This block takes the receive side of a 100 Mb/s RMII PHY link and turns it into a byte stream. It runs on the 50 MHz reference clock that the PHY shares. On each rising edge it samples the two receive data lines and the combined carrier-sense/data-valid line. Once armed, it waits for carrier. It then treats the first dibit with the upper data line high as the start marker. That marker is the final dibit of the start-of-frame delimiter, so the dibit after it is the first data dibit.

Data dibits are packed least significant first into bytes. Each finished byte leaves on a valid/data stream that has no ready input. The downstream side has to take every byte in the cycle it is presented, because the line rate cannot be paused. The receiver tests carrier once per pair of dibits. When it sees carrier low, it captures one more dibit to absorb a possible half-dibit slip, then closes the frame. At the close it gives one end-of-frame pulse together with the frame's byte count and the number of bits left over in the unfinished byte, which is discarded. After a frame closes the receiver stays halted. The enable must go low for at least one cycle and then high again before the next frame can be received.

Top module: `rmii_frame_rx`

## Requirements
- R1: A synchronous active-high reset returns the receiver to waiting for carrier. It clears `m_valid`, `eof`, `eof_bytes` and `eof_drop` to zero.
- R2: No frame starts while `en` is low, and no frame starts before `crs_dv` has been seen high. A high `rxd[1]` that arrives without carrier does not start a frame.
- R3: After carrier is seen, the first sampled dibit with `rxd[1]`=1 is the start marker and is not captured. Capture begins with the next dibit.
- R4: Bit 0 of a dibit is `rxd[0]` and bit 1 is `rxd[1]`. The first data dibit of each group of four goes to `m_data[1:0]` and the fourth goes to `m_data[7:6]`. `m_valid` is high for exactly one cycle, the cycle after the edge that samples the fourth dibit. There is no back-pressure.
- R5: `crs_dv` is examined only at the edge that samples the 2nd, 4th, 6th, … captured dibit. A low `crs_dv` at any other captured dibit has no effect.
- R6: When `crs_dv` is seen low, exactly one further dibit is captured. `eof` is then high for one cycle, the cycle after that edge. It coincides with `m_valid` if that dibit completes a byte.
- R7: With `eof`, `eof_bytes` gives the number of bytes emitted in the frame, including one finished by the trailing dibit. The value holds until the next frame close.
- R8: With `eof`, `eof_drop` gives the number of discarded bits, which is twice the number of dibits left in the unfinished byte (0, 2, 4 or 6). The value holds until the next frame close.
- R9: After a close the receiver ignores the link until `en` has been low for at least one cycle and is high again.
- R10: `en` going low while data is being captured abandons the frame. No further byte and no `eof` is produced for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock shared with the PHY |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Arms the receiver; a low-to-high sequence re-arms after a close |
| rxd | input | 2 | Receive dibit, bit 0 = first data line, bit 1 = second |
| crs_dv | input | 1 | Carrier sense / data valid from the PHY |
| m_valid | output | 1 | One-cycle strobe: `m_data` holds a new byte |
| m_data | output | BYTE_W | Assembled byte, first dibit in the low bits |
| eof | output | 1 | One-cycle end-of-frame pulse |
| eof_bytes | output | CNT_W | Bytes emitted in the frame just closed |
| eof_drop | output | DROP_W | Bits discarded from the unfinished last byte |

## Verification
On every cycle the assertions check the following. Byte strobes and end-of-frame pulses never last longer than one cycle. The discarded-bit count is even whenever it is reported. Reset leaves the outputs quiet. Two cycles of low enable silence the output. Only the bench scenarios can show the rest, each compared clock by clock against a behavioural model: that the start marker is skipped, that bytes are in dibit order, that carrier is tested only on pair boundaries, that the trailing dibit is taken, that the counts are correct, that a receiver halted after a frame stays deaf, and that an abandoned frame produces nothing.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_CRS,
    ST_WAIT_SOF,
    ST_RECV,
    ST_TAIL,
    ST_HALT
  } rx_state_t;
endpackage

// File: rtl/rmii_rx_ctrl.sv
module rmii_rx_ctrl
  import rmii_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic crs_dv,
  input  logic sof_bit,
  input  logic pair_last,
  output logic cap,
  output logic clr,
  output logic close
);
  rx_state_t st, st_nxt;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_WAIT_CRS: if (en && crs_dv) st_nxt = ST_WAIT_SOF;
      ST_WAIT_SOF: begin
        if (!en)          st_nxt = ST_WAIT_CRS;
        else if (sof_bit) st_nxt = ST_RECV;
      end
      ST_RECV: begin
        if (!en)                       st_nxt = ST_WAIT_CRS;
        else if (pair_last && !crs_dv) st_nxt = ST_TAIL;
      end
      ST_TAIL: st_nxt = ST_HALT;
      ST_HALT: if (!en) st_nxt = ST_WAIT_CRS;
      default: st_nxt = ST_WAIT_CRS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_WAIT_CRS;
    else     st <= st_nxt;
  end

  // The trailing dibit is taken whatever en does; abandoning happens only in RECV.
  assign cap   = (st == ST_RECV && en) || (st == ST_TAIL);
  assign clr   = (st == ST_WAIT_SOF);
  assign close = (st == ST_TAIL);
endmodule

// File: rtl/rmii_rx_pack.sv
module rmii_rx_pack #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cap,
  input  logic [1:0]        rxd,
  output logic              m_valid,
  output logic [BYTE_W-1:0] m_data,
  output logic              byte_done,
  output logic              pair_last,
  output logic [IDX_W-1:0]  nxt_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTE_W / 2 - 1);

  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-3:0] hold;   // earlier dibits of the byte in progress
  logic [BYTE_W-1:0] word;

  assign word      = {rxd, hold};
  assign byte_done = cap && (idx == LAST);
  assign pair_last = idx[0];
  assign nxt_idx   = idx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      hold    <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      m_valid <= byte_done;
      if (byte_done) m_data <= word;
      if (clr) begin
        idx <= '0;
      end else if (cap) begin
        idx  <= nxt_idx;
        hold <= {rxd, hold[BYTE_W-3:2]};
      end
    end
  end
endmodule

// File: rtl/rmii_rx_count.sv
module rmii_rx_count #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             close,
  input  logic             byte_done,
  input  logic [IDX_W-1:0] nxt_idx,
  output logic             eof,
  output logic [CNT_W-1:0] eof_bytes,
  output logic [IDX_W:0]   eof_drop
);
  logic [CNT_W-1:0] cnt, cnt_inc;

  assign cnt_inc = cnt + CNT_W'(byte_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      eof       <= 1'b0;
      eof_bytes <= '0;
      eof_drop  <= '0;
    end else begin
      eof <= close;
      cnt <= clr ? '0 : cnt_inc;
      if (close) begin
        eof_bytes <= cnt_inc;
        eof_drop  <= {nxt_idx, 1'b0};
      end
    end
  end
endmodule

// File: rtl/rmii_frame_rx.sv
module rmii_frame_rx #(
  parameter  int BYTE_W = 8,
  parameter  int CNT_W  = 16,
  localparam int IDX_W  = $clog2(BYTE_W / 2),
  localparam int DROP_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        rxd,
  input  logic              crs_dv,
  output logic              m_valid,
  output logic [BYTE_W-1:0] m_data,
  output logic              eof,
  output logic [CNT_W-1:0]  eof_bytes,
  output logic [DROP_W-1:0] eof_drop
);
  logic cap, clr, close, byte_done, pair_last;
  logic [IDX_W-1:0] nxt_idx;

  rmii_rx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .en(en), .crs_dv(crs_dv), .sof_bit(rxd[1]),
    .pair_last(pair_last), .cap(cap), .clr(clr), .close(close)
  );

  rmii_rx_pack #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_pack (
    .clk(clk), .rst(rst), .clr(clr), .cap(cap), .rxd(rxd),
    .m_valid(m_valid), .m_data(m_data), .byte_done(byte_done),
    .pair_last(pair_last), .nxt_idx(nxt_idx)
  );

  rmii_rx_count #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_count (
    .clk(clk), .rst(rst), .clr(clr), .close(close), .byte_done(byte_done),
    .nxt_idx(nxt_idx), .eof(eof), .eof_bytes(eof_bytes), .eof_drop(eof_drop)
  );
endmodule

// File: rtl/rmii_frame_rx_chk.sv
module rmii_frame_rx_chk #(
  parameter int DROP_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              m_valid,
  input logic              eof,
  input logic [DROP_W-1:0] eof_drop
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!m_valid && !eof && eof_drop == '0));

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    m_valid |=> !m_valid);

  assert_eof_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    eof |=> !eof);

  assert_drop_even_R8: assert property (@(posedge clk) disable iff (rst)
    eof |-> !eof_drop[0]);

  assert_disabled_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(en)) |=> (!m_valid && !eof));
endmodule

bind rmii_frame_rx rmii_frame_rx_chk #(.DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .m_valid(m_valid), .eof(eof), .eof_drop(eof_drop)
);

// File: tb/test_rmii_frame_rx.sv
module test_rmii_frame_rx;
  logic clk = 1'b0, rst = 1'b1, en = 1'b0, crs = 1'b0;
  logic [1:0] rx = 2'b00;
  logic m_valid, eof;
  logic [7:0] m_data;
  logic [15:0] eof_bytes;
  logic [2:0] eof_drop;

  rmii_frame_rx i_rmii_frame_rx (
    .clk(clk), .rst(rst), .en(en), .rxd(rx), .crs_dv(crs),
    .m_valid(m_valid), .m_data(m_data), .eof(eof),
    .eof_bytes(eof_bytes), .eof_drop(eof_drop)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string scen = "R1";
  bit started = 0, done = 0;

  // Behavioural reference: mode 0 idle, 1 seeking marker, 2 capturing, 3 tail, 4 halted.
  int mode = 0, nd = 0, nb = 0, ebytes = 0, edrop = 0;
  logic [1:0] dq[$];
  logic ev = 0, ee = 0;
  logic [7:0] edata = 0;

  task automatic take(input logic [1:0] d);
    dq.push_back(d);
    nd++;
    if (dq.size() == 4) begin
      edata = {dq[3], dq[2], dq[1], dq[0]};
      dq.delete();
      ev = 1;
      nb = (nb + 1) % 65536;
    end
  endtask

  always @(posedge clk) begin
    ev = 0; ee = 0; started = 1;
    if (rst) begin
      mode = 0; nd = 0; nb = 0; dq.delete(); ebytes = 0; edrop = 0; edata = 0;
    end else begin
      case (mode)
        0: if (en && crs) mode = 1;
        1: if (!en) mode = 0;
           else if (rx[1]) begin mode = 2; nd = 0; nb = 0; dq.delete(); end
        2: if (!en) mode = 0;
           else begin take(rx); if (nd % 2 == 0 && !crs) mode = 3; end
        3: begin take(rx); ee = 1; ebytes = nb; edrop = 2 * dq.size(); mode = 4; end
        default: if (!en) mode = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [scenario %s] actual=%0d expected=%0d at %0t", tag, scen, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R4 m_valid", m_valid, ev);
      if (ev) chk("R4 m_data", m_data, edata);
      chk("R6 eof", eof, ee);
      chk("R7 eof_bytes", eof_bytes, ebytes);
      chk("R8 eof_drop", eof_drop, edrop);
    end
  end

  task automatic drive(input logic e, input logic c, input logic [1:0] r);
    @(negedge clk);
    en = e; crs = c; rx = r;
  endtask

  // Preamble, start marker, bytes, extra dibits, carrier drop; optional glitch
  // of crs_dv on an even data dibit (R5) and optional re-arm (R9).
  task automatic frame(input int nbytes, input int extra, input bit fixed,
                       input int glitch_at, input bit rearm);
    int j = 0;
    repeat (6) drive(1, 1, 2'b01);
    drive(1, 1, 2'b11);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b;
      b = fixed ? 8'(8'hC6 + 8'(i * 37)) : 8'($urandom);
      for (int k = 0; k < 4; k++) begin
        drive(1, (j == glitch_at) ? 1'b0 : 1'b1, b[2*k +: 2]);
        j++;
      end
    end
    for (int i = 0; i < extra; i++) drive(1, 1, 2'($urandom));
    repeat (4) drive(1, 0, 2'b00);
    if (rearm) drive(0, 0, 2'b00);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    drive(0, 0, 2'b00);
    // R1: quiet outputs after reset
    chk("R1 m_valid", m_valid, 0);
    chk("R1 eof", eof, 0);
    chk("R1 eof_bytes", eof_bytes, 0);
    chk("R1 eof_drop", eof_drop, 0);

    scen = "R2";   // marker without carrier, then traffic while disabled
    repeat (6) drive(1, 0, 2'b11);
    drive(0, 0, 2'b00);
    repeat (24) drive(0, 1, 2'($urandom));
    drive(0, 0, 2'b00);

    scen = "R3";   // known bytes, marker skipped
    frame(1, 0, 1, -1, 1);
    frame(2, 1, 1, -1, 1);
    scen = "R6";   // trailing dibit and pulse with different alignments
    frame(3, 2, 0, -1, 1);
    frame(4, 3, 0, -1, 1);
    scen = "R5";   // carrier low on even dibits is not examined
    frame(3, 0, 0, 4, 1);
    frame(2, 1, 0, 2, 1);
    scen = "R9";   // halted receiver stays deaf until re-armed
    frame(2, 0, 0, -1, 0);
    frame(3, 1, 0, -1, 1);
    frame(1, 2, 0, -1, 1);

    scen = "R10";  // abandon mid-frame by dropping enable
    repeat (6) drive(1, 1, 2'b01);
    drive(1, 1, 2'b11);
    repeat (5) drive(1, 1, 2'($urandom));
    repeat (3) drive(0, 1, 2'($urandom));
    repeat (3) drive(0, 0, 2'b00);

    scen = "R7";
    for (int f = 0; f < 6; f++) frame(1 + f * 3, f % 4, 0, -1, 1);
    repeat (4) drive(0, 0, 2'b00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule